// File: doc/BRIEF.md
# Paired-Cancel Memory Scanner

This block reads every location of a synchronous single-port memory, one word per clock, and returns the one non-zero value that occurs only once. The memory may hold any number of other non-zero values, provided each of them occurs exactly twice. All remaining locations are zero.

The block folds each word it reads into a single accumulator using XOR. A value that occurs twice cancels itself, and zero words have no effect, so the accumulator ends holding the lone value. The only storage is the accumulator, one word wide, plus the address counter. Neither grows with the number of pairs.

A start pulse launches a scan, and a one-cycle done pulse marks the result as final. The memory is assumed to return read data one cycle after the request.

Top module: `xor_scan_finder`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` and `memRe` are 0 and `result` is 0.
- R2: A start sampled while idle makes `memRe` high for exactly 2^ADDR_W consecutive cycles, beginning in the next cycle. During those cycles `memAddr` runs 0, 1, 2, … 2^ADDR_W−1, rising by one each cycle.
- R3: The word for the request made in cycle t is taken from `memRdata` at the end of cycle t+1, which matches a one-cycle memory read latency.
- R4: The final result is the XOR of every word read in the scan. For memory contents that meet the pairing rule, it equals the lone non-zero value, wherever that value is placed.
- R5: `done` is high for exactly one cycle per scan. That cycle is the 2^ADDR_W+2-th cycle after the cycle in which start was sampled, and `result` is final in that cycle.
- R6: `result` holds its value from the `done` cycle until the next accepted start.
- R7: A start that arrives while a scan, its drain cycle or its done cycle is in progress is ignored. It triggers no second address sweep and no second `done`, and it leaves the result unchanged.
- R8: An accepted start clears the accumulator, so a scan of an all-zero memory returns 0 even after a scan that returned a non-zero value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a scan |
| memAddr | output | ADDR_W | Read address to the memory |
| memRe | output | 1 | Read enable to the memory |
| memRdata | input | DATA_W | Read data, valid one cycle after `memRe` |
| done | output | 1 | One-cycle pulse: scan finished |
| result | output | DATA_W | Lone value found by the scan |

## Verification
If the address counter is off, the fault appears in the read-enable and address sequence in the first cycle of the sweep, or in a `done` pulse that arrives early or late. If the accumulator is mistimed relative to the read latency, or is not cleared, the result is wrong by the `done` cycle of that same scan. An accumulator that is corrupted after a scan shows up as a `result` that changes during the cycles between `done` and the next start. A start that should be ignored but leaks through shows up within one cycle as a restarted address sweep or a second `done`.

// File: rtl/xor_scan_pkg.sv
package xor_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } scanState_t;

  // Strobes from the sequencer to the accumulator datapath.
  typedef struct packed {
    logic clrAcc;
    logic accEn;
  } dpCtl_t;

endpackage

// File: rtl/xor_scan_ctrl.sv
module xor_scan_ctrl
  import xor_scan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              done,
  output dpCtl_t            dpCtl
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  scanState_t        stateQ;
  logic [ADDR_W-1:0] addrQ;
  logic              rdPendQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      addrQ   <= '0;
      rdPendQ <= 1'b0;
    end else begin
      rdPendQ <= (stateQ == ST_SCAN);
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ <= ST_SCAN;
            addrQ  <= '0;
          end
        end
        ST_SCAN: begin
          if (addrQ == LAST_ADDR) begin
            stateQ <= ST_DRAIN;
          end else begin
            addrQ <= addrQ + ADDR_W'(1);
          end
        end
        ST_DRAIN: stateQ <= ST_FIN;
        ST_FIN:   stateQ <= ST_IDLE;
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memRe        = (stateQ == ST_SCAN);
    memAddr      = addrQ;
    done         = (stateQ == ST_FIN);
    dpCtl.clrAcc = (stateQ == ST_IDLE) && start;
    dpCtl.accEn  = rdPendQ;
  end

  // R2: a sweep opens at address zero
  p_sweep_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memRe) |-> memAddr == '0);

  // R2: consecutive reads step the address by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (memRe && $past(memRe)) |-> memAddr == $past(memAddr) + ADDR_W'(1));

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: no read is issued while completion is flagged
  p_no_read_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !memRe);

  // R3: the accumulate strobe follows each read request by one cycle
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    memRe |=> dpCtl.accEn);

endmodule

// File: rtl/xor_scan_dp.sv
module xor_scan_dp
  import xor_scan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] accQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ <= '0;
    end else if (dpCtl.clrAcc) begin
      accQ <= '0;
    end else if (dpCtl.accEn) begin
      accQ <= accQ ^ memRdata;
    end
  end

  assign result = accQ;

  // R8: a clear strobe leaves the accumulator at zero
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dpCtl.clrAcc |=> result == '0);

  // R6: without a strobe the accumulator keeps its value
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpCtl.clrAcc && !dpCtl.accEn) |=> $stable(result));

  // R7: clear and accumulate never coincide
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dpCtl.clrAcc && dpCtl.accEn));

endmodule

// File: rtl/xor_scan_finder.sv
module xor_scan_finder
  import xor_scan_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  dpCtl_t dpCtl;

  xor_scan_ctrl #(
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .memAddr (memAddr),
    .memRe   (memRe),
    .done    (done),
    .dpCtl   (dpCtl)
  );

  xor_scan_dp #(
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dpCtl    (dpCtl),
    .memRdata (memRdata),
    .result   (result)
  );

endmodule

// File: tb/xor_scan_finder_tb.sv
module xor_scan_finder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int MAX_PAIRS  = (DEPTH - 1) / 2;
  localparam int WDOG_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [ADDR_W-1:0] memAddr;
  logic              memRe;
  logic [DATA_W-1:0] memRdata;
  logic              done;
  logic [DATA_W-1:0] result;

  logic [DATA_W-1:0] memArr [DEPTH];

  int compared   = 0;
  int mismatched = 0;
  int cycCount   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model with a one-cycle read latency (R3)
  always_ff @(posedge clk) begin
    if (memRe) memRdata <= memArr[memAddr];
  end

  xor_scan_finder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .memAddr  (memAddr),
    .memRe    (memRe),
    .memRdata (memRdata),
    .done     (done),
    .result   (result)
  );

  always @(posedge clk) begin
    cycCount <= cycCount + 1;
    if (cycCount == WDOG_LIMIT) begin
      mismatched = mismatched + 1;
      compared   = compared + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycCount, WDOG_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] valOf(input int idx, input int trial);
    return DATA_W'(((idx * 37 + trial * 11) % 254) + 1);
  endfunction

  // Fill memory: n pairs plus one lone value at address uAddr (or random if negative)
  task automatic fillMem(input int nPairs, input int uAddr, input int trial,
                         output logic [DATA_W-1:0] lone);
    int slot[DEPTH];
    for (int i = 0; i < DEPTH; i++) begin
      slot[i] = i;
      memArr[i] = '0;
    end
    for (int i = DEPTH - 1; i > 0; i--) begin
      int r;
      int t;
      r = $urandom_range(i, 0);
      t = slot[i]; slot[i] = slot[r]; slot[r] = t;
    end
    if (uAddr >= 0) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot[i] == uAddr) begin
          slot[i] = slot[0];
          slot[0] = uAddr;
        end
      end
    end
    lone = valOf(nPairs, trial);
    memArr[slot[0]] = lone;
    for (int i = 0; i < nPairs; i++) begin
      memArr[slot[1 + 2*i]] = valOf(i, trial);
      memArr[slot[2 + 2*i]] = valOf(i, trial);
    end
  endtask

  // One scan: start sampled at edge e0; sample at negedge j (cycle e(j-1)..e(j))
  task automatic runScan(input logic [DATA_W-1:0] expVal, input int injectAt, input string tag);
    bit seqOk = 1;
    int badAct = 0;
    int badExp = 0;
    int doneCnt = 0;
    int doneAt = -1;
    logic [DATA_W-1:0] atDone = '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= DEPTH + 6; j++) begin
      if (j > 1) @(negedge clk);
      start = 1'b0;
      if (j <= DEPTH) begin
        if (!(memRe && memAddr == ADDR_W'(j - 1)) && seqOk) begin
          seqOk = 0; badAct = {memRe, memAddr}; badExp = {1'b1, ADDR_W'(j - 1)};
        end
      end else if (memRe && seqOk) begin
        seqOk = 0; badAct = {memRe, memAddr}; badExp = 0;
      end
      if (done) begin
        doneCnt++;
        doneAt = j;
        atDone = result;
      end
      if (j == injectAt) start = 1'b1;
    end
    check(seqOk, {"R2 read sweep ", tag}, badAct, badExp);
    check(doneCnt == 1 && doneAt == DEPTH + 2, {"R5 done timing ", tag}, doneAt, DEPTH + 2);
    check(atDone == expVal, {"R4 R3 result at done ", tag}, atDone, expVal);
    check(result == expVal && !done, {"R6 R7 result held ", tag}, result, expVal);
  endtask

  initial begin
    logic [DATA_W-1:0] lone;
    logic [DATA_W-1:0] xacc;
    start = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) memArr[i] = '0;
    repeat (3) @(negedge clk);
    check(!done && !memRe && result == '0, "R1 reset outputs", {done, memRe, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !memRe && result == '0, "R1 after reset", {done, memRe, result}, 0);

    // Sweep pair counts, several placements each
    for (int n = 0; n <= MAX_PAIRS; n++) begin
      for (int t = 0; t < 3; t++) begin
        fillMem(n, -1, n * 3 + t, lone);
        runScan(lone, 0, $sformatf("pairs=%0d trial=%0d", n, t));
      end
    end

    // Lone value at every address, memory full of pairs
    for (int u = 0; u < DEPTH; u++) begin
      fillMem(MAX_PAIRS, u, 50 + u, lone);
      runScan(lone, 0, $sformatf("lone at %0d", u));
    end

    // R7: starts injected mid-sweep, in drain and in the done cycle
    fillMem(4, -1, 90, lone);
    runScan(lone, 3, "R7 start mid sweep");
    fillMem(5, -1, 91, lone);
    runScan(lone, DEPTH + 1, "R7 start in drain");
    fillMem(6, -1, 92, lone);
    runScan(lone, DEPTH + 2, "R7 start at done");

    // R8: all-zero memory after a non-zero result
    for (int i = 0; i < DEPTH; i++) memArr[i] = '0;
    runScan('0, 0, "R8 zero memory");

    // R4: arbitrary contents give the XOR of all words
    for (int t = 0; t < 4; t++) begin
      xacc = '0;
      for (int i = 0; i < DEPTH; i++) begin
        memArr[i] = DATA_W'($urandom);
        xacc = xacc ^ memArr[i];
      end
      runScan(xacc, 0, $sformatf("R4 arbitrary %0d", t));
    end

    // R6: result stays put over idle cycles
    repeat (20) @(negedge clk);
    check(result == xacc && !done && !memRe, "R6 idle hold", result, xacc);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule